// File: doc/BRIEF.md
# Rewindable Dual-Set Receive FIFO

This block buffers received packet bytes for a single endpoint between a serial engine and a CPU. The serial side pushes one byte per cycle into a circular store. A marker remembers where the packet now arriving began. At the end of a packet the writer either keeps the bytes, which closes them into a readable data set with a known byte count, or discards them as a unit by winding its write pointer back to the marker. A corrupted packet therefore never becomes visible to the CPU, and its space can be refilled when the host retries.

At most two closed data sets are tracked at once. The CPU reads the oldest one byte by byte through a first-word-fall-through port: the byte at the read pointer is always on the data output while the set still has unread bytes. When it has finished with a set, the CPU must release it explicitly by raising a read-advance request. This sets an advance bit that clears itself after one cycle, once the read side has moved to the next set. Keep and discard can be driven by explicit strobes. In automatic mode they can also be driven by the serial engine's good/bad end-of-packet events.

Top module: `rx_rewind_fifo`

## Requirements
- R1: Bytes accepted from the write port are returned on `rd_data` in write order. `rd_data` shows the byte at the read pointer whenever `empty` is low, and each `rd_en` with `empty` low advances to the next byte at the following clock edge.
- R2: A keep action turns every byte accepted since the marker into a new data set and moves the marker to the write pointer. `cnt_cur` reports the byte count of the oldest held set and `cnt_next` the count of the second one. Each count reads 0 when that set is absent, and `sets_held` gives the number of held sets (0, 1 or 2).
- R3: A discard action moves the write pointer back to the marker. The discarded bytes never become readable, are not counted, and their space is free again.
- R4: `fw_commit` and `fw_rewind` request keep and discard in any mode. `ev_ok` and `ev_err` request keep and discard only while `auto_en` is 1, and are ignored while it is 0. When a keep request and a discard request occur in the same cycle, the discard wins.
- R5: A write presented in a cycle that carries any keep or discard request is dropped.
- R6: `full` is high when two sets are held, or when DEPTH bytes lie between the start of the oldest held set (or the marker, if no set is held) and the write pointer. A write presented while `full` is high is dropped.
- R7: `empty` is high when no set is held or the read pointer has reached the end of the oldest set. `rd_en` while `empty` is high is ignored, and reads never cross into the second set.
- R8: A one-cycle `adv_req` pulse raises `adv_busy` in the next cycle. At the end of that cycle the oldest set is released, the read pointer moves to the start of the following data, and `adv_busy` drops again. `rd_en` during the `adv_busy` cycle is ignored.
- R9: A read advance that finds no held set only pulses `adv_busy`. Pointers, counts and flags stay unchanged.
- R10: A keep action while two sets are held is ignored, and `sets_held` never exceeds 2.
- R11: After reset, `empty` is 1 and `full`, `sets_held`, `cnt_cur`, `cnt_next` and `adv_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | Lets serial-engine events keep or discard packets |
| wr_valid | input | 1 | Serial side presents a byte |
| wr_data | input | DATA_W | Byte to store |
| ev_ok | input | 1 | Serial engine: packet received good |
| ev_err | input | 1 | Serial engine: packet received bad |
| fw_commit | input | 1 | Explicit keep strobe |
| fw_rewind | input | 1 | Explicit discard strobe |
| rd_en | input | 1 | CPU consumes the byte on rd_data |
| adv_req | input | 1 | CPU releases the set it has read |
| rd_data | output | DATA_W | Byte at the read pointer |
| empty | output | 1 | No readable byte in the current set |
| full | output | 1 | Writer must not write |
| adv_busy | output | 1 | Self-clearing read-advance bit |
| sets_held | output | 2 | Number of held data sets |
| cnt_cur | output | $clog2(DEPTH)+1 | Byte count of the set being read |
| cnt_next | output | $clog2(DEPTH)+1 | Byte count of the second set |

## Verification
The properties make no assumption about input legality. Writes while full, reads while empty, keep and discard in the same cycle, and advances with nothing held are all allowed to happen, and the properties only require known input values once reset is released. The stimulus therefore leaves every input defined in every cycle. Directed sequences step through those overlapping cases on purpose: a keep with a write, a discard beside an automatic keep, a fill past DEPTH, and a keep with two sets held. A long random phase then mixes all strobes freely, with a small advance rate so that both sets fill regularly.

// File: rtl/rx_rewind_fifo_pkg.sv
package rx_rewind_fifo_pkg;

    // End-of-packet action selected for one cycle
    typedef enum logic [1:0] {
        EOP_NONE   = 2'd0,
        EOP_KEEP   = 2'd1,
        EOP_REWIND = 2'd2
    } eop_act_e;

    // Discard outranks keep; keep needs a free set slot
    function automatic eop_act_e pick_action(input logic discard_req,
                                             input logic keep_req,
                                             input logic slot_free);
        if (discard_req)
            return EOP_REWIND;
        else if (keep_req && slot_free)
            return EOP_KEEP;
        else
            return EOP_NONE;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl
    import rx_rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic          wr_valid,
    input  logic          ev_ok,
    input  logic          ev_err,
    input  logic          fw_commit,
    input  logic          fw_rewind,
    input  logic [1:0]    sets_held,
    input  logic [PW-1:0] tail,
    output logic          mem_we,
    output logic [AW-1:0] wr_addr,
    output logic          full,
    output logic          push,
    output logic [PW-1:0] push_start,
    output logic [PW-1:0] push_cnt,
    output logic [PW-1:0] mark
);

    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] mark;
    } wr_state_t;

    wr_state_t q, d;
    eop_act_e  act;
    logic      keep_req;
    logic      drop_req;
    logic      used_full;
    logic      accept;

    always_comb begin
        d         = q;
        keep_req  = fw_commit | (auto_en & ev_ok);
        drop_req  = fw_rewind | (auto_en & ev_err);
        act       = pick_action(drop_req, keep_req, sets_held < 2'd2);
        used_full = (q.wr_ptr - tail) == CAP;
        full      = used_full | (sets_held == 2'd2);
        accept    = wr_valid & ~full & ~keep_req & ~drop_req;

        if (accept)
            d.wr_ptr = q.wr_ptr + 1'b1;

        unique case (act)
            EOP_KEEP:   d.mark   = q.wr_ptr;
            EOP_REWIND: d.wr_ptr = q.mark;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign mem_we     = accept;
    assign wr_addr    = q.wr_ptr[AW-1:0];
    assign push       = (act == EOP_KEEP);
    assign push_start = q.mark;
    assign push_cnt   = q.wr_ptr - q.mark;
    assign mark       = q.mark;

endmodule

// File: rtl/rxf_set_trk.sv
module rxf_set_trk #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int NSET = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          adv_req,
    input  logic          push,
    input  logic [PW-1:0] push_start,
    input  logic [PW-1:0] push_cnt,
    input  logic [PW-1:0] mark,
    output logic [AW-1:0] rd_addr,
    output logic          empty,
    output logic [1:0]    sets_held,
    output logic [PW-1:0] tail,
    output logic [PW-1:0] cnt_cur,
    output logic [PW-1:0] cnt_next,
    output logic          adv_busy
);

    typedef struct packed {
        logic [NSET-1:0][PW-1:0] start;
        logic [NSET-1:0][PW-1:0] cnt;
        logic [1:0]              held;
        logic [PW-1:0]           rd_ptr;
        logic                    busy;
    } set_state_t;

    set_state_t q, d;
    logic       release_set;
    logic [1:0] held_after;
    logic [PW-1:0] set_end;

    always_comb begin
        d           = q;
        set_end     = q.start[0] + q.cnt[0];
        empty       = (q.held == 2'd0) | (q.rd_ptr == set_end);
        release_set = q.busy & (q.held != 2'd0);
        held_after  = q.held;

        if (release_set) begin
            for (int s = 0; s < NSET - 1; s++) begin
                d.start[s] = q.start[s+1];
                d.cnt[s]   = q.cnt[s+1];
            end
            d.start[NSET-1] = '0;
            d.cnt[NSET-1]   = '0;
            d.rd_ptr        = set_end;
            held_after      = q.held - 1'b1;
        end else if (rd_en && !empty) begin
            d.rd_ptr = q.rd_ptr + 1'b1;
        end

        if (push) begin
            if (held_after == 2'd0) begin
                d.start[0] = push_start;
                d.cnt[0]   = push_cnt;
            end else begin
                d.start[1] = push_start;
                d.cnt[1]   = push_cnt;
            end
        end

        d.held = held_after + {1'b0, push};
        d.busy = adv_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rd_addr   = q.rd_ptr[AW-1:0];
    assign sets_held = q.held;
    assign tail      = (q.held != 2'd0) ? q.start[0] : mark;
    assign cnt_cur   = (q.held != 2'd0) ? q.cnt[0] : '0;
    assign cnt_next  = (q.held == 2'd2) ? q.cnt[1] : '0;
    assign adv_busy  = q.busy;

endmodule

// File: rtl/rx_rewind_fifo.sv
module rx_rewind_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_ok,
    input  logic              ev_err,
    input  logic              fw_commit,
    input  logic              fw_rewind,
    input  logic              rd_en,
    input  logic              adv_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              adv_busy,
    output logic [1:0]        sets_held,
    output logic [PW-1:0]     cnt_cur,
    output logic [PW-1:0]     cnt_next
);

    logic          mem_we;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          push;
    logic [PW-1:0] push_start;
    logic [PW-1:0] push_cnt;
    logic [PW-1:0] mark;
    logic [PW-1:0] tail;

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    rxf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .wr_valid   (wr_valid),
        .ev_ok      (ev_ok),
        .ev_err     (ev_err),
        .fw_commit  (fw_commit),
        .fw_rewind  (fw_rewind),
        .sets_held  (sets_held),
        .tail       (tail),
        .mem_we     (mem_we),
        .wr_addr    (wr_addr),
        .full       (full),
        .push       (push),
        .push_start (push_start),
        .push_cnt   (push_cnt),
        .mark       (mark)
    );

    rxf_set_trk #(.DEPTH(DEPTH)) u_sets (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .adv_req    (adv_req),
        .push       (push),
        .push_start (push_start),
        .push_cnt   (push_cnt),
        .mark       (mark),
        .rd_addr    (rd_addr),
        .empty      (empty),
        .sets_held  (sets_held),
        .tail       (tail),
        .cnt_cur    (cnt_cur),
        .cnt_next   (cnt_next),
        .adv_busy   (adv_busy)
    );

endmodule

// File: rtl/rx_rewind_fifo_chk.sv
module rx_rewind_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PW    = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_en,
    input logic              ev_ok,
    input logic              ev_err,
    input logic              fw_commit,
    input logic              fw_rewind,
    input logic              rd_en,
    input logic              adv_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              full,
    input logic              adv_busy,
    input logic [1:0]        sets_held,
    input logic [PW-1:0]     cnt_cur,
    input logic [PW-1:0]     cnt_next
);

    logic keep_any;
    logic drop_any;
    assign keep_any = fw_commit | (auto_en & ev_ok);
    assign drop_any = fw_rewind | (auto_en & ev_err);

    p_sets_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sets_held != 2'd3);

    p_empty_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sets_held == 2'd0) |-> empty);

    p_full_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sets_held == 2'd2) |-> full);

    p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_cur} + {1'b0, cnt_next}) <= (PW+1)'(DEPTH));

    p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv_req |=> adv_busy);

    p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_busy && !adv_req) |=> !adv_busy);

    p_hold_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_en && !adv_busy) |=> (!empty && $stable(rd_data)));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sets_held != 2'd0 && !adv_busy) |=> $stable(cnt_cur));

    p_keep_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_commit && !drop_any && sets_held == 2'd0 && !adv_busy)
        |=> (sets_held == 2'd1));

    p_rewind_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_any && !adv_busy) |=> (sets_held == $past(sets_held)));

    p_adv_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_busy && sets_held == 2'd0 && !keep_any) |=> (sets_held == 2'd0));

endmodule

bind rx_rewind_fifo rx_rewind_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .ev_ok     (ev_ok),
    .ev_err    (ev_err),
    .fw_commit (fw_commit),
    .fw_rewind (fw_rewind),
    .rd_en     (rd_en),
    .adv_req   (adv_req),
    .rd_data   (rd_data),
    .empty     (empty),
    .full      (full),
    .adv_busy  (adv_busy),
    .sets_held (sets_held),
    .cnt_cur   (cnt_cur),
    .cnt_next  (cnt_next)
);

// File: tb/test_rx_rewind_fifo.sv
module test_rx_rewind_fifo;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 64;
    localparam int PW     = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              auto_en = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ev_ok = 1'b0;
    logic              ev_err = 1'b0;
    logic              fw_commit = 1'b0;
    logic              fw_rewind = 1'b0;
    logic              rd_en = 1'b0;
    logic              adv_req = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              empty;
    logic              full;
    logic              adv_busy;
    logic [1:0]        sets_held;
    logic [PW-1:0]     cnt_cur;
    logic [PW-1:0]     cnt_next;

    always #2.5 clk = ~clk;

    rx_rewind_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_rewind_fifo (
        .clk (clk), .rst_n (rst_n), .auto_en (auto_en),
        .wr_valid (wr_valid), .wr_data (wr_data),
        .ev_ok (ev_ok), .ev_err (ev_err),
        .fw_commit (fw_commit), .fw_rewind (fw_rewind),
        .rd_en (rd_en), .adv_req (adv_req),
        .rd_data (rd_data), .empty (empty), .full (full),
        .adv_busy (adv_busy), .sets_held (sets_held),
        .cnt_cur (cnt_cur), .cnt_next (cnt_next)
    );

    // ---------------- behavioural reference ----------------
    logic [DATA_W-1:0] m_bytes[$];   // bytes of kept sets, oldest first
    int                m_cnt[$];     // byte count per kept set
    logic [DATA_W-1:0] m_pend[$];    // bytes of the packet in flight
    int                m_rd;         // read offset inside oldest set
    bit                m_busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R11 reset";
    bit    done = 1'b0;

    function automatic int m_occ();
        int s = m_pend.size();
        foreach (m_cnt[i]) s += m_cnt[i];
        return s;
    endfunction

    function automatic bit m_empty();
        return (m_cnt.size() == 0) || (m_rd == m_cnt[0]);
    endfunction

    function automatic bit m_full();
        return (m_cnt.size() == 2) || (m_occ() == DEPTH);
    endfunction

    always @(posedge clk or negedge rst_n) begin : ref_model
        bit keep_r, drop_r, fire, e0, f0;
        int n0;
        if (!rst_n) begin
            m_bytes.delete(); m_cnt.delete(); m_pend.delete();
            m_rd = 0; m_busy = 1'b0;
        end else begin
            keep_r = fw_commit || (auto_en && ev_ok);
            drop_r = fw_rewind || (auto_en && ev_err);
            fire   = m_busy && (m_cnt.size() > 0);
            e0     = m_empty();
            f0     = m_full();
            n0     = m_cnt.size();
            if (rd_en && !e0 && !fire) m_rd++;
            if (fire) begin
                repeat (m_cnt[0]) void'(m_bytes.pop_front());
                void'(m_cnt.pop_front());
                m_rd = 0;
            end
            if (wr_valid && !f0 && !keep_r && !drop_r) m_pend.push_back(wr_data);
            if (drop_r) m_pend.delete();
            else if (keep_r && n0 < 2) begin
                m_cnt.push_back(m_pend.size());
                foreach (m_pend[i]) m_bytes.push_back(m_pend[i]);
                m_pend.delete();
            end
            m_busy = adv_req;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d",
                     tag, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        check("R7 empty",      empty,     m_empty());
        check("R6 full",       full,      m_full());
        check("R2 sets_held",  sets_held, m_cnt.size());
        check("R2 cnt_cur",    cnt_cur,   (m_cnt.size() > 0) ? m_cnt[0] : 0);
        check("R2 cnt_next",   cnt_next,  (m_cnt.size() > 1) ? m_cnt[1] : 0);
        check("R8 adv_busy",   adv_busy,  m_busy);
        if (!m_empty())
            check("R1 rd_data", rd_data, m_bytes[m_rd]);
    endtask

    // one clock: inputs already driven, compare after the edge, clear strobes
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        wr_valid = 0; ev_ok = 0; ev_err = 0; fw_commit = 0;
        fw_rewind = 0; rd_en = 0; adv_req = 0;
    endtask

    task automatic put(int n);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1; wr_data = DATA_W'($urandom); tick();
        end
    endtask

    task automatic take(int n);
        for (int i = 0; i < n; i++) begin
            rd_en = 1; tick();
        end
    endtask

    task automatic release_set();
        adv_req = 1; tick();
        rd_en = 1; tick();      // read during busy cycle is ignored (R8)
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R11 reset";
        compare();

        phase = "R1 R2 keep and read";
        put(5); fw_commit = 1; tick();
        take(7);                         // two extra reads hit empty (R7)
        release_set();

        phase = "R3 rewind";
        put(4); fw_rewind = 1; tick();
        put(3); fw_commit = 1; tick();
        take(3); release_set();

        phase = "R4 auto mode";
        put(2); ev_ok = 1; tick();       // auto off: ignored
        auto_en = 1; ev_ok = 1; tick();  // keeps 2 bytes
        put(3); ev_err = 1; tick();      // discards 3
        put(2); ev_ok = 1; fw_rewind = 1; tick();  // discard wins
        auto_en = 0;
        take(2); release_set();

        phase = "R5 write with end request";
        put(2); wr_valid = 1; wr_data = 8'hA5; fw_commit = 1; tick();
        take(3); release_set();

        phase = "R6 fill";
        put(DEPTH + 2);
        fw_commit = 1; tick();
        take(3); put(1); release_set();
        put(DEPTH);
        fw_commit = 1; tick();
        release_set();

        phase = "R10 two sets";
        put(2); fw_commit = 1; tick();
        put(3); fw_commit = 1; tick();
        put(1); fw_commit = 1; tick();   // ignored, two held
        take(1); release_set(); take(4); release_set();

        phase = "R9 advance with nothing held";
        release_set(); put(1); release_set(); fw_rewind = 1; tick();

        phase = "random mix";
        for (int c = 0; c < 6000; c++) begin
            auto_en   = ($urandom % 4) != 0;
            wr_valid  = ($urandom % 10) < 6;
            wr_data   = DATA_W'($urandom);
            ev_ok     = ($urandom % 12) == 0;
            ev_err    = ($urandom % 40) == 0;
            fw_commit = ($urandom % 30) == 0;
            fw_rewind = ($urandom % 80) == 0;
            rd_en     = ($urandom % 2) == 0;
            adv_req   = ($urandom % 25) == 0;
            tick();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule